// File: doc/BRIEF.md
# Multiplexed Status Output Generator

This block drives one push-pull status pin from a four-way selector. Two of the four sources are level inputs from elsewhere in the device: the ready/operate level, which rises only once the device can run after power-up or a reset-pin reset, and the supply-detect comparator level. The block builds the other two sources itself.

The first is a bus-activity flag. It is set by a packet sync strobe and cleared by bus reset, or after a run of idle (J-state) bit times. The second is a start-of-frame square wave. It rises on each frame-start strobe and falls after half a frame of clock cycles, which gives about 50% duty over a full-speed 1 ms frame.

The two-bit select input is meant to come from a pin-control register that resets to 00, so the ready level is shown by default. The pin is registered, so it cannot glitch when the select field or a source changes.

The activity tracker is a two-state machine: `ACT_QUIET` and `ACT_BUSY`. Its transitions are:
- quiet-to-busy on a sync strobe without bus reset;
- busy-to-quiet on bus reset;
- busy-to-quiet on the idle timeout, taken when the last idle bit arrives without a sync strobe.

The frame wave generator is a two-state machine: `FW_LOW` and `FW_HIGH`. Its transitions are:
- low-to-high on a frame-start strobe;
- high-to-high (restart) on a frame-start strobe;
- high-to-low when the half-frame count expires.

Top module: `status_pin_mux`

## Requirements
- R1: While `rst_n` is low, `status_pin` is 0, the activity flag is cleared and the frame wave is low.
- R2: With `sel` = 2'b00, `status_pin` equals `ready_lvl` as sampled at the previous rising clock edge.
- R3: With `sel` = 2'b01, `status_pin` equals `supply_lvl` as sampled at the previous rising clock edge.
- R4: With `sel` = 2'b10, the pin shows the activity flag. A `sync_stb` sampled at edge n (without `bus_rst`) sets the flag at edge n, and the pin goes high at edge n+1.
- R5: `bus_rst` clears the activity flag at the edge where it is sampled, and it takes priority over a simultaneous `sync_stb`.
- R6: The flag clears at the edge where the IDLE_BITS-th (default 32) consecutive `bit_stb` with `j_idle`=1 is sampled. A `bit_stb` with `j_idle`=0, or a `sync_stb`, restarts the count from zero. Cycles without `bit_stb` do not break the run.
- R7: With `sel` = 2'b11, the pin shows the frame wave. A `frame_stb` at edge n makes the wave high from edge n for HALF_FRAME_CLKS cycles, after which it goes low. The pin follows one edge later.
- R8: A `frame_stb` that arrives while the wave is high keeps the wave high and restarts its HALF_FRAME_CLKS high period.
- R9: Once cleared, the activity flag stays low until the next `sync_stb`. Idle or non-idle bit strobes do not set it.
- R10: A change of `sel` takes effect at `status_pin` on the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel | input | 2 | Source select: 00 ready, 01 supply detect, 10 bus activity, 11 frame wave |
| ready_lvl | input | 1 | Ready/operate level |
| supply_lvl | input | 1 | Supply-detect comparator level |
| sync_stb | input | 1 | One-cycle strobe: packet sync pattern detected |
| bus_rst | input | 1 | Bus reset in progress (level) |
| j_idle | input | 1 | Line is in idle (J) state (level) |
| bit_stb | input | 1 | One-cycle strobe per bus bit time |
| frame_stb | input | 1 | One-cycle strobe at each frame start |
| status_pin | output | 1 | Registered push-pull status output |

## Verification
The hardest case to reach is the idle-timeout boundary. The flag must survive 31 idle bits and then drop exactly on the 32nd. It must also survive when the run is broken by a non-idle bit or a fresh sync one bit short of the limit.

The stimulus reaches this case by driving long trains of bit strobes with `j_idle` held high. Some trains have gaps between the strobes, and some have a single non-idle bit or a sync strobe placed just before the limit.

The early frame-start restart is also reached on purpose, by issuing a second strobe a few cycles into a high period. A cycle-level reference in the bench predicts the pin for every cycle.

// File: rtl/status_mux_pkg.sv
package status_mux_pkg;

    typedef enum logic [1:0] {
        SEL_READY    = 2'b00,
        SEL_SUPPLY   = 2'b01,
        SEL_ACTIVITY = 2'b10,
        SEL_FRAME    = 2'b11
    } pin_sel_e;

    typedef enum logic {
        ACT_QUIET = 1'b0,
        ACT_BUSY  = 1'b1
    } act_state_e;

    typedef enum logic {
        FW_LOW  = 1'b0,
        FW_HIGH = 1'b1
    } fw_state_e;

endpackage

// File: rtl/activity_tracker.sv
module activity_tracker
    import status_mux_pkg::*;
#(
    parameter int IDLE_BITS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_stb,
    input  logic bus_rst,
    input  logic j_idle,
    input  logic bit_stb,
    output logic act_flag
);

    localparam int CW = $clog2(IDLE_BITS + 1);
    localparam logic [CW-1:0] LAST_IDLE = CW'(IDLE_BITS - 1);

    act_state_e      state_q, state_n;
    logic [CW-1:0]   idle_cnt_q;
    logic            idle_tick;
    logic            idle_break;

    assign idle_tick  = bit_stb & j_idle;
    assign idle_break = bit_stb & ~j_idle;

    // next state
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ACT_QUIET: begin
                if (sync_stb && !bus_rst) state_n = ACT_BUSY;
            end
            ACT_BUSY: begin
                if (bus_rst)
                    state_n = ACT_QUIET;
                else if (!sync_stb && idle_tick && idle_cnt_q == LAST_IDLE)
                    state_n = ACT_QUIET;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ACT_QUIET;
        else        state_q <= state_n;
    end

    // idle bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            idle_cnt_q <= '0;
        else if (state_n == ACT_QUIET || sync_stb || idle_break)
            idle_cnt_q <= '0;
        else if (idle_tick)
            idle_cnt_q <= idle_cnt_q + CW'(1);
    end

    // outputs
    always_comb begin
        act_flag = (state_q == ACT_BUSY);
    end

endmodule

// File: rtl/frame_wave_gen.sv
module frame_wave_gen
    import status_mux_pkg::*;
#(
    parameter int HALF_FRAME_CLKS = 60000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_stb,
    output logic wave_lvl
);

    localparam int HW = $clog2(HALF_FRAME_CLKS + 1);
    localparam logic [HW-1:0] LAST_HIGH = HW'(HALF_FRAME_CLKS - 1);

    fw_state_e     state_q, state_n;
    logic [HW-1:0] high_cnt_q;

    // next state
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            FW_LOW: begin
                if (frame_stb) state_n = FW_HIGH;
            end
            FW_HIGH: begin
                if (!frame_stb && high_cnt_q == LAST_HIGH) state_n = FW_LOW;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FW_LOW;
        else        state_q <= state_n;
    end

    // high-period counter, restarted by every frame strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            high_cnt_q <= '0;
        else if (frame_stb || state_n == FW_LOW)
            high_cnt_q <= '0;
        else
            high_cnt_q <= high_cnt_q + HW'(1);
    end

    // outputs
    always_comb begin
        wave_lvl = (state_q == FW_HIGH);
    end

endmodule

// File: rtl/status_pin_mux.sv
module status_pin_mux
    import status_mux_pkg::*;
#(
    parameter int IDLE_BITS       = 32,
    parameter int HALF_FRAME_CLKS = 60000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel,
    input  logic       ready_lvl,
    input  logic       supply_lvl,
    input  logic       sync_stb,
    input  logic       bus_rst,
    input  logic       j_idle,
    input  logic       bit_stb,
    input  logic       frame_stb,
    output logic       status_pin
);

    logic     act_flag;
    logic     wave_lvl;
    logic     pin_d;
    logic     pin_q;
    pin_sel_e sel_e;

    assign sel_e = pin_sel_e'(sel);

    activity_tracker #(
        .IDLE_BITS (IDLE_BITS)
    ) act_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_stb (sync_stb),
        .bus_rst  (bus_rst),
        .j_idle   (j_idle),
        .bit_stb  (bit_stb),
        .act_flag (act_flag)
    );

    frame_wave_gen #(
        .HALF_FRAME_CLKS (HALF_FRAME_CLKS)
    ) wave_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_stb (frame_stb),
        .wave_lvl  (wave_lvl)
    );

    always_comb begin
        unique case (sel_e)
            SEL_READY:    pin_d = ready_lvl;
            SEL_SUPPLY:   pin_d = supply_lvl;
            SEL_ACTIVITY: pin_d = act_flag;
            SEL_FRAME:    pin_d = wave_lvl;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_q <= 1'b0;
        else        pin_q <= pin_d;
    end

    assign status_pin = pin_q;

endmodule

// File: rtl/status_pin_mux_chk.sv
module status_pin_mux_chk #(
    parameter int HALF_FRAME_CLKS = 60000
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] sel,
    input logic       ready_lvl,
    input logic       supply_lvl,
    input logic       sync_stb,
    input logic       bus_rst,
    input logic       frame_stb,
    input logic       act_flag,
    input logic       wave_lvl,
    input logic       status_pin
);

    localparam int RW = $clog2(HALF_FRAME_CLKS + 2) + 1;

    logic [RW-1:0] hi_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         hi_run <= '0;
        else if (frame_stb) hi_run <= RW'(1);
        else if (wave_lvl)  hi_run <= hi_run + RW'(1);
        else                hi_run <= '0;
    end

    assert_ready_route_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b00) |=> (status_pin == $past(ready_lvl)));

    assert_supply_route_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b01) |=> (status_pin == $past(supply_lvl)));

    assert_sync_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_stb && !bus_rst) |=> act_flag);

    assert_busrst_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst |=> !act_flag);

    assert_stays_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_flag && !sync_stb) |=> !act_flag);

    assert_frame_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |=> wave_lvl);

    assert_high_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wave_lvl |-> (hi_run <= RW'(HALF_FRAME_CLKS)));

endmodule

bind status_pin_mux status_pin_mux_chk #(
    .HALF_FRAME_CLKS (HALF_FRAME_CLKS)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel        (sel),
    .ready_lvl  (ready_lvl),
    .supply_lvl (supply_lvl),
    .sync_stb   (sync_stb),
    .bus_rst    (bus_rst),
    .frame_stb  (frame_stb),
    .act_flag   (act_flag),
    .wave_lvl   (wave_lvl),
    .status_pin (status_pin)
);

// File: tb/status_pin_mux_tb_top.sv
module status_pin_mux_tb_top;

    localparam int IDLE  = 32;
    localparam int HALF  = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] sel = 2'b00;
    logic       ready_lvl = 1'b0, supply_lvl = 1'b0, sync_stb = 1'b0, bus_rst = 1'b0;
    logic       j_idle = 1'b0, bit_stb = 1'b0, frame_stb = 1'b0;
    logic       status_pin;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic  exp;
        string tag;
    } item_t;
    item_t sb_q[$];

    // reference state
    logic m_act = 1'b0;
    int   m_cnt = 0;
    logic m_wave = 1'b0;
    int   m_wcnt = 0;

    always #4 clk = ~clk;

    status_pin_mux #(
        .IDLE_BITS       (IDLE),
        .HALF_FRAME_CLKS (HALF)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (sel),
        .ready_lvl  (ready_lvl),
        .supply_lvl (supply_lvl),
        .sync_stb   (sync_stb),
        .bus_rst    (bus_rst),
        .j_idle     (j_idle),
        .bit_stb    (bit_stb),
        .frame_stb  (frame_stb),
        .status_pin (status_pin)
    );

    task automatic check(input logic got, input logic exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: status_pin=%0b expected %0b", tag, got, exp);
        end
    endtask

    // driver: apply one cycle of inputs, push the expected pin value
    task automatic cyc(input logic [1:0] s, input logic rdy, input logic sup,
                       input logic syn, input logic brst, input logic j,
                       input logic bt, input logic fst, input string tag);
        item_t it;
        @(negedge clk);
        sel = s; ready_lvl = rdy; supply_lvl = sup; sync_stb = syn;
        bus_rst = brst; j_idle = j; bit_stb = bt; frame_stb = fst;
        case (s)
            2'b00:   it.exp = rdy;
            2'b01:   it.exp = sup;
            2'b10:   it.exp = m_act;
            default: it.exp = m_wave;
        endcase
        it.tag = tag;
        sb_q.push_back(it);
        // activity flag per R4, R5, R6, R9
        if (brst) begin
            m_act = 1'b0; m_cnt = 0;
        end else if (syn) begin
            m_act = 1'b1; m_cnt = 0;
        end else if (bt && !j) begin
            m_cnt = 0;
        end else if (m_act && bt && j) begin
            if (m_cnt == IDLE - 1) begin
                m_act = 1'b0; m_cnt = 0;
            end else begin
                m_cnt++;
            end
        end
        // frame wave per R7, R8
        if (fst) begin
            m_wave = 1'b1; m_wcnt = 0;
        end else if (m_wave) begin
            if (m_wcnt == HALF - 1) begin
                m_wave = 1'b0; m_wcnt = 0;
            end else begin
                m_wcnt++;
            end
        end
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                check(status_pin, it.exp, it.tag);
            end
        end
    end

    // watchdog
    initial begin
        #(8 * 20000);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: status_pin=%0b expected run to end", status_pin);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state, with sources driven high
        ready_lvl = 1'b1; supply_lvl = 1'b1;
        repeat (3) @(negedge clk);
        check(status_pin, 1'b0, "R1 pin low in reset");
        sel = 2'b01;
        @(negedge clk);
        check(status_pin, 1'b0, "R1 pin low in reset, sel 01");
        sel = 2'b00; ready_lvl = 1'b0; supply_lvl = 1'b0;
        rst_n = 1'b1;

        // R1: cleared sources right after reset
        cyc(2'b10, 0, 0, 0, 0, 1, 0, 0, "R1 activity flag cleared");
        cyc(2'b11, 0, 0, 0, 0, 1, 0, 0, "R1 frame wave cleared");

        // R2: ready level
        for (int i = 0; i < 8; i++)
            cyc(2'b00, logic'((i / 2) % 2), logic'(i % 2), 0, 0, 0, 0, 0, "R2");
        // R3: supply level
        for (int i = 0; i < 8; i++)
            cyc(2'b01, logic'(i % 2), logic'((i / 3) % 2), 0, 0, 0, 0, 0, "R3");

        // R4: sync sets the flag
        cyc(2'b10, 0, 0, 1, 0, 0, 1, 0, "R4");
        for (int i = 0; i < 6; i++)
            cyc(2'b10, 0, 0, 0, 0, 0, 1, 0, "R4");

        // R5: bus reset clears, and wins over sync
        cyc(2'b10, 0, 0, 0, 1, 0, 0, 0, "R5");
        cyc(2'b10, 0, 0, 1, 1, 0, 0, 0, "R5");
        cyc(2'b10, 0, 0, 0, 0, 0, 0, 0, "R5");
        cyc(2'b10, 0, 0, 0, 0, 0, 0, 0, "R5");

        // R6: idle timeout, with interruptions
        cyc(2'b10, 0, 0, 1, 0, 1, 0, 0, "R6");
        for (int i = 0; i < 20; i++)
            cyc(2'b10, 0, 0, 0, 0, 1, 1, 0, "R6");
        cyc(2'b10, 0, 0, 0, 0, 0, 1, 0, "R6 K bit");
        for (int i = 0; i < IDLE - 1; i++)
            cyc(2'b10, 0, 0, 0, 0, 1, 1, 0, "R6");
        cyc(2'b10, 0, 0, 1, 0, 1, 0, 0, "R6 resync");
        for (int i = 0; i < IDLE; i++) begin
            cyc(2'b10, 0, 0, 0, 0, 1, 1, 0, "R6 gapped");
            cyc(2'b10, 0, 0, 0, 0, 1, 0, 0, "R6 gapped");
            cyc(2'b10, 0, 0, 0, 0, 1, 0, 0, "R6 gapped");
        end

        // R9: stays low without sync
        for (int i = 0; i < 12; i++)
            cyc(2'b10, 0, 0, 0, 0, logic'(i % 2), 1, 0, "R9");

        // R7: frame wave period
        cyc(2'b11, 0, 0, 0, 0, 0, 0, 1, "R7");
        for (int i = 0; i < HALF + 5; i++)
            cyc(2'b11, 0, 0, 0, 0, 0, 0, 0, "R7");
        cyc(2'b11, 0, 0, 0, 0, 0, 0, 1, "R7");
        for (int i = 0; i < HALF + 3; i++)
            cyc(2'b11, 0, 0, 0, 0, 0, 0, 0, "R7");

        // R8: early strobe restarts the high period
        cyc(2'b11, 0, 0, 0, 0, 0, 0, 1, "R8");
        for (int i = 0; i < 4; i++)
            cyc(2'b11, 0, 0, 0, 0, 0, 0, 0, "R8");
        cyc(2'b11, 0, 0, 0, 0, 0, 0, 1, "R8");
        for (int i = 0; i < HALF + 4; i++)
            cyc(2'b11, 0, 0, 0, 0, 0, 0, 0, "R8");

        // R10: select changes every cycle
        cyc(2'b00, 1, 0, 1, 0, 0, 0, 1, "R10");
        for (int i = 0; i < 16; i++)
            cyc(2'(i % 4), 1, 0, 0, 0, 0, 0, 0, "R10");
        for (int i = 0; i < 8; i++)
            cyc(2'(3 - (i % 4)), logic'(i % 2), logic'((i + 1) % 2), 0, 0, 0, 0, 0, "R10");

        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule